// File: doc/BRIEF.md
# Peripheral Request Router

This block sits between a set of peripheral request lines and the channels of a DMA engine. Each request line owns one small mapping entry that holds a valid flag and a target channel number. The block registers the incoming request levels and merges every line whose entry is valid into the level of its target channel. It also turns changes on those levels into one-cycle event pulses that the channel status logic can record:

- a rising pulse when a channel's request becomes active;
- a pulse that clears that flag when the request activity changes in any other way;
- an end-of-receive pulse when a channel's request goes inactive.

The mapping entries are reached through a plain single-cycle register port. Writes take effect at the clock edge. Reads are combinational from the address. There is no data stream through this block, so no port carries a valid/ready handshake. The request levels and all outputs are plain level or pulse signals with no back-pressure.

Two address windows hold the entries. The first 64 entries sit in a low window. The remaining entries sit in a separate high window, so `NUM_REQ` must lie between 65 and 128. A write that marks an entry valid but names a channel that does not exist is refused. The refused write leaves the entry as it was and raises an error pulse.

Top module: `dreq_map`

## Requirements
- R1: After reset every entry is invalid with channel 0, and `ch_req`, `ras_set`, `ras_clr`, `eor_pulse` and `map_err` are all zero.
- R2: An entry stores write-data bit 7 as its valid flag and bits 4:0 as its channel number. A read of the entry returns the valid flag in bit 7, the channel in bits 4:0 and zero in all other bits.
- R3: Entry i for i < 64 is at byte address 0x100 + 4*i. Entry i for i >= 64 is at 0x1100 + 4*(i-64). Addresses past the last entry and addresses that are not word aligned read zero, and writes to them change nothing.
- R4: The three request-status words at 0xE0, 0xE4 and 0xE8 always read zero, and writes to them change no entry.
- R5: A write with bit 7 set and a channel number >= `NUM_CH` leaves the entry unchanged and makes `map_err` high for exactly the one cycle after the write edge. A write with bit 7 clear is accepted whatever its channel number.
- R6: `ch_req[c]` is the OR of all request lines whose entry is valid with channel c. It follows an input change after the second rising clock edge.
- R7: A request line whose entry is invalid has no effect on any channel level or event pulse.
- R8: `ras_set[c]` pulses for one cycle, together with the new level, when `ch_req[c]` goes from 0 to 1.
- R9: `ras_clr[c]` pulses for one cycle when a line mapped to channel c toggles, or when the level of channel c changes, but never in the cycle where channel c rises.
- R10: `eor_pulse[c]` pulses for one cycle, together with the new level, when `ch_req[c]` goes from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | NUM_REQ | Peripheral request levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 16 | Register byte address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data (combinational) |
| map_err | output | 1 | Pulse: a mapping write was refused |
| ch_req | output | NUM_CH | Merged request level per channel |
| ras_set | output | NUM_CH | Pulse: channel request became active |
| ras_clr | output | NUM_CH | Pulse: clear the request-became-active flag |
| eor_pulse | output | NUM_CH | Pulse: channel request went inactive |

## Verification
The bench builds the router with the full 75 request lines and only 6 channels. With 75 lines, both address windows and the exact end of the high window can be reached. With 6 channels, channel numbers 6 to 31 can be written as refused values, and several lines fall on each channel, which brings the OR merging and the clear events from secondary lines within reach. Every entry is written and read back. Every line is toggled on its own, and a set of computed multi-line patterns checks the merged levels and the edge pulses against a model in the bench.

// File: rtl/dreq_map_pkg.sv
package dreq_map_pkg;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 32;
  localparam int CH_FIELD_W = 5;
  localparam int VLD_BIT    = 7;
  localparam int LO_COUNT   = 64;
  localparam logic [7:0] LO_PAGE = 8'h01;
  localparam logic [7:0] HI_PAGE = 8'h11;

  typedef struct packed {
    logic                  vld;
    logic [CH_FIELD_W-1:0] ch;
  } map_entry_t;
endpackage

// File: rtl/dreq_map_regs.sv
module dreq_map_regs
  import dreq_map_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  output logic [DATA_W-1:0]               rdata,
  output logic                            map_err,
  output map_entry_t [NUM_REQ-1:0]        map_o
);
  localparam int HI_COUNT = NUM_REQ - LO_COUNT;
  localparam int IDX_W    = $clog2(NUM_REQ);

  map_entry_t [NUM_REQ-1:0] map_q;
  logic                     hit;
  logic [IDX_W-1:0]         idx;
  logic                     bad_ch;
  logic                     unused_wdata;

  assign unused_wdata = ^{wdata[DATA_W-1:VLD_BIT+1], wdata[VLD_BIT-1:CH_FIELD_W]};

  // Two windows: low page holds entries 0..63, high page holds the rest.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr[15:8] == LO_PAGE) begin
        hit = 1'b1;
        idx = IDX_W'(addr[7:2]);
      end else if (addr[15:8] == HI_PAGE && int'(addr[7:2]) < HI_COUNT) begin
        hit = 1'b1;
        idx = IDX_W'(LO_COUNT + int'(addr[7:2]));
      end
    end
  end

  assign bad_ch = wdata[VLD_BIT] && (int'(wdata[CH_FIELD_W-1:0]) >= NUM_CH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q   <= '0;
      map_err <= 1'b0;
    end else begin
      map_err <= wr_en && hit && bad_ch;
      if (wr_en && hit && !bad_ch) begin
        map_q[idx] <= '{vld: wdata[VLD_BIT], ch: wdata[CH_FIELD_W-1:0]};
      end
    end
  end

  // Status words and unmatched addresses fall through to zero.
  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[VLD_BIT]          = map_q[idx].vld;
      rdata[CH_FIELD_W-1:0]   = map_q[idx].ch;
    end
  end

  assign map_o = map_q;

  a_r4_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[15:8] == 8'h00) |=> $stable(map_q));

  a_r5_refused_write_keeps_table: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bad_ch) |=> $stable(map_q));

  a_r5_error_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    map_err |-> $past(wr_en));
endmodule

// File: rtl/dreq_map_route.sv
module dreq_map_route
  import dreq_map_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_REQ-1:0]       req_in,
  input  map_entry_t [NUM_REQ-1:0] map_i,
  output logic [NUM_CH-1:0]        ch_req,
  output logic [NUM_CH-1:0]        ras_set,
  output logic [NUM_CH-1:0]        ras_clr,
  output logic [NUM_CH-1:0]        eor_pulse
);
  logic [NUM_REQ-1:0] req_q;
  logic [NUM_REQ-1:0] req_p;
  logic [NUM_CH-1:0]  lvl_now;
  logic [NUM_CH-1:0]  touched;
  logic [NUM_CH-1:0]  rising;

  // Merge every validly mapped line into its channel; note line toggles.
  always_comb begin
    lvl_now = '0;
    touched = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (map_i[i].vld && map_i[i].ch == CH_FIELD_W'(c)) begin
          lvl_now[c] = lvl_now[c] | req_q[i];
          touched[c] = touched[c] | (req_q[i] ^ req_p[i]);
        end
      end
    end
  end

  assign rising = lvl_now & ~ch_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q     <= '0;
      req_p     <= '0;
      ch_req    <= '0;
      ras_set   <= '0;
      ras_clr   <= '0;
      eor_pulse <= '0;
    end else begin
      req_q     <= req_in;
      req_p     <= req_q;
      ch_req    <= lvl_now;
      ras_set   <= rising;
      eor_pulse <= ~lvl_now & ch_req;
      ras_clr   <= (touched | (lvl_now ^ ch_req)) & ~rising;
    end
  end

  a_r8_set_only_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_set & ~(ch_req & ~$past(ch_req))) == '0);

  a_r10_eor_only_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (eor_pulse & ~(~ch_req & $past(ch_req))) == '0);

  a_r6_level_change_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_req ^ $past(ch_req)) & ~(ras_set | eor_pulse)) == '0);

  a_r9_clear_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (eor_pulse & ~ras_clr) == '0);
endmodule

// File: rtl/dreq_map.sv
module dreq_map
  import dreq_map_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_in,
  input  logic               wr_en,
  input  logic [15:0]        addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic               map_err,
  output logic [NUM_CH-1:0]  ch_req,
  output logic [NUM_CH-1:0]  ras_set,
  output logic [NUM_CH-1:0]  ras_clr,
  output logic [NUM_CH-1:0]  eor_pulse
);
  map_entry_t [NUM_REQ-1:0] map_tbl;

  dreq_map_regs #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .map_err (map_err),
    .map_o   (map_tbl)
  );

  dreq_map_route #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_in    (req_in),
    .map_i     (map_tbl),
    .ch_req    (ch_req),
    .ras_set   (ras_set),
    .ras_clr   (ras_clr),
    .eor_pulse (eor_pulse)
  );
endmodule

// File: tb/dreq_map_tb.sv
module dreq_map_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 75;
  localparam int NC = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] req_in = '0;
  logic          wr_en = 1'b0;
  logic [15:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          map_err;
  logic [NC-1:0] ch_req, ras_set, ras_clr, eor_pulse;

  int checks = 0;
  int errors = 0;

  dreq_map #(.NUM_REQ(NR), .NUM_CH(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .map_err(map_err), .ch_req(ch_req),
    .ras_set(ras_set), .ras_clr(ras_clr), .eor_pulse(eor_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit ev(int i); return (i % 5) != 3; endfunction
  function automatic int ec(int i); return (i * 7) % NC; endfunction
  function automatic logic [15:0] a_of(int i);
    return (i < 64) ? 16'(32'h100 + 4*i) : 16'(32'h1100 + 4*(i-64));
  endfunction
  function automatic logic [31:0] ent(bit v, int c);
    return {24'b0, v, 2'b00, 5'(c)};
  endfunction
  function automatic logic [NC-1:0] merge(logic [NR-1:0] p);
    logic [NC-1:0] r = '0;
    for (int i = 0; i < NR; i++) if (ev(i) && p[i]) r[ec(i)] = 1'b1;
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [NR-1:0] pat, lfsr;
    logic [NC-1:0] prev, cur, one;
    @(negedge clk); step(); step();
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 ch_req", 64'(ch_req), 0);
    chk("R1 pulses", 64'({ras_set, ras_clr, eor_pulse}), 0);
    chk("R1 map_err", 64'(map_err), 0);
    rd(a_of(0), d);  chk("R1 entry0", 64'(d), 0);
    rd(a_of(74), d); chk("R1 entry74", 64'(d), 0);

    // R2/R3 program every entry with extra junk bits, read all back
    for (int i = 0; i < NR; i++) wr(a_of(i), ent(ev(i), ec(i)) | 32'hF000_0060);
    for (int i = 0; i < NR; i++) begin
      rd(a_of(i), d);
      chk(i < 64 ? "R3 low window / R2 fields" : "R3 high window / R2 fields",
          64'(d), 64'(ent(ev(i), ec(i))));
    end
    rd(16'h1100 + 16'(4*11), d); chk("R3 past last entry", 64'(d), 0);
    rd(16'h0102, d);             chk("R3 misaligned", 64'(d), 0);
    wr(16'h1100 + 16'(4*11), 32'h0000_0081);
    rd(a_of(74), d);             chk("R3 write past end", 64'(d), 64'(ent(ev(74), ec(74))));

    // R4 status words
    wr(16'h00E0, 32'hFFFF_FFFF); wr(16'h00E4, 32'hFFFF_FFFF); wr(16'h00E8, 32'hFFFF_FFFF);
    rd(16'h00E0, d); chk("R4 status0", 64'(d), 0);
    rd(16'h00E4, d); chk("R4 status1", 64'(d), 0);
    rd(16'h00E8, d); chk("R4 status2", 64'(d), 0);
    rd(a_of(56), d); chk("R4 table intact", 64'(d), 64'(ent(ev(56), ec(56))));

    // R5 out-of-range channel numbers
    for (int c = NC; c < 32; c += 5) begin
      wr(a_of(5), ent(1'b1, c));
      chk("R5 map_err raised", 64'(map_err), 1);
      step();
      chk("R5 map_err one cycle", 64'(map_err), 0);
      rd(a_of(5), d); chk("R5 entry kept", 64'(d), 64'(ent(ev(5), ec(5))));
    end
    wr(a_of(68), ent(1'b0, 20));
    chk("R5 invalid write no error", 64'(map_err), 0);
    rd(a_of(68), d); chk("R5 invalid write stored", 64'(d), 64'(ent(1'b0, 20)));
    wr(a_of(68), ent(ev(68), ec(68)));

    // R6-R10 each line alone
    for (int i = 0; i < NR; i++) begin
      one = ev(i) ? NC'(1) << ec(i) : '0;
      req_in = NR'(1) << i;
      step(); step();
      chk(ev(i) ? "R6 single line level" : "R7 invalid line level", 64'(ch_req), 64'(one));
      chk("R8 set on rise", 64'(ras_set), 64'(one));
      chk("R9 no clear on rise", 64'(ras_clr), 0);
      chk("R10 no eor on rise", 64'(eor_pulse), 0);
      step();
      chk("R8 set lasts one cycle", 64'(ras_set), 0);
      req_in = '0;
      step(); step();
      chk("R10 eor on fall", 64'(eor_pulse), 64'(one));
      chk(ev(i) ? "R9 clear on fall" : "R7 invalid line no pulse", 64'(ras_clr), 64'(one));
      chk("R6 level drops", 64'(ch_req), 0);
      step();
    end

    // R9 two lines sharing channel 0 (lines 0 and 6)
    req_in = NR'(1); step(); step();
    chk("R8 shared first rise", 64'(ras_set), 1);
    req_in = NR'(1) | (NR'(1) << 6); step(); step();
    chk("R9 second line clears", 64'(ras_clr), 1);
    chk("R8 no set while active", 64'(ras_set), 0);
    chk("R6 level held", 64'(ch_req), 1);
    req_in = NR'(1) << 6; step(); step();
    chk("R9 first line drop clears", 64'(ras_clr), 1);
    chk("R10 no eor while other active", 64'(eor_pulse), 0);
    req_in = '0; step(); step();
    chk("R10 final drop eor", 64'(eor_pulse), 1);
    step();

    // R6 multi-line patterns
    lfsr = NR'(75'h5A5_1234_ABCD_9876_0F0F);
    prev = '0;
    for (int k = 0; k < 24; k++) begin
      lfsr = {lfsr[NR-2:0], lfsr[NR-1] ^ lfsr[NR-7] ^ lfsr[0]};
      pat = lfsr & (lfsr >> 3) & (k[0] ? {NR{1'b1}} : (lfsr >> 1));
      req_in = pat; step(); step();
      cur = merge(pat);
      chk("R6 pattern level", 64'(ch_req), 64'(cur));
      chk("R8 pattern set", 64'(ras_set), 64'(cur & ~prev));
      chk("R10 pattern eor", 64'(eor_pulse), 64'(prev & ~cur));
      prev = cur;
    end
    finish_run();
  end
endmodule